// File: doc/BRIEF.md
# Three-Component Combined Tausworthe Uniform Generator

This block produces one 32-bit uniformly distributed word per clock for a stochastic simulation core. Internally it keeps three 32-bit state words. Each word advances with its own recurrence: a left shift, a low-bit mask and an XOR. The output word is the XOR of the three advanced words. A Gaussian noise source typically instantiates two copies with different seeds. It then turns their outputs into fractions and shapes them, and that work happens outside this block.

A seed-load strobe writes all three state words in one cycle. A seed below the lock-up threshold of its component (2, 8 or 16) would hold that component at zero forever, so the block raises such a seed by adding the threshold before storing it. A step-enable input advances the generator by one step. When the step-enable is low, the state and the output are held.

Top module: `taus3_urng`

## Requirements
- R1: On reset (rst_n low, asynchronous) rnd_out is 0 and rnd_vld is 0. The three state words take their defaults a=32'h1234_5678, b=32'h9ABC_DEF0, c=32'h0F1E_2D3C, so the first step after reset gives the output of R5 computed from these values.
- R2: Word a advances as t = ((a<<13)^a)>>19, a' = ((a & 32'hFFFF_FFFE)<<12) ^ t.
- R3: Word b advances as t = ((b<<2)^b)>>25, b' = ((b & 32'hFFFF_FFF8)<<4) ^ t.
- R4: Word c advances as t = ((c<<3)^c)>>11, c' = ((c & 32'hFFFF_FFF0)<<17) ^ t. All shifts in R2 to R4 are 32-bit logical shifts.
- R5: In a cycle where step_en is high and seed_we is low, all three words advance together. On the following clock edge, rnd_out becomes a'^b'^c' and rnd_vld becomes 1.
- R6: In a cycle where step_en and seed_we are both low, the state does not change, rnd_vld is 0 on the next edge and rnd_out keeps its value.
- R7: When seed_we is high, the words are loaded from seed_a, seed_b and seed_c. A seed below its threshold (2 for a, 8 for b, 16 for c) is stored as the seed plus that threshold. seed_we takes priority over step_en. rnd_vld is 0 on the next edge and rnd_out is held.
- R8: After any seed load or reset, a stays at 2 or above, b at 8 or above and c at 16 or above, for every later step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_we | input | 1 | Load all three seeds this cycle |
| seed_a | input | 32 | Seed for word a |
| seed_b | input | 32 | Seed for word b |
| seed_c | input | 32 | Seed for word c |
| step_en | input | 1 | Advance the generator one step |
| rnd_out | output | 32 | Combined uniform word |
| rnd_vld | output | 1 | rnd_out was produced by a step on the previous edge |

## Verification
A table of seed triples runs the generator for a number of steps each, and every output is compared with a bit-exact model.
- Seeds made of all ones exercise every mask and shift path at once.
- Seeds with a single high bit separate the shifted term from the feedback term of each component.
- Seeds set exactly at the thresholds, and one below them, test the lock-up fix.
- Directed cases interleave idle cycles with steps, and assert load and step in the same cycle, to show the hold and priority rules.
- A long run confirms that no component drifts from the model.

// File: rtl/taus3_urng.sv
module taus3_urng #(
  parameter logic [31:0] DEF_A = 32'h1234_5678,
  parameter logic [31:0] DEF_B = 32'h9ABC_DEF0,
  parameter logic [31:0] DEF_C = 32'h0F1E_2D3C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        seed_we,
  input  logic [31:0] seed_a,
  input  logic [31:0] seed_b,
  input  logic [31:0] seed_c,
  input  logic        step_en,
  output logic [31:0] rnd_out,
  output logic        rnd_vld
);
  localparam logic [31:0] MIN_A = 32'd2;
  localparam logic [31:0] MIN_B = 32'd8;
  localparam logic [31:0] MIN_C = 32'd16;

  logic [31:0] st_a, st_b, st_c;
  logic [31:0] nx_a, nx_b, nx_c;
  logic [31:0] fb_a, fb_b, fb_c;
  logic [31:0] ld_a, ld_b, ld_c;
  logic        adv;

  assign fb_a = ((st_a << 13) ^ st_a) >> 19;
  assign fb_b = ((st_b << 2)  ^ st_b) >> 25;
  assign fb_c = ((st_c << 3)  ^ st_c) >> 11;

  assign nx_a = ((st_a & 32'hFFFF_FFFE) << 12) ^ fb_a;
  assign nx_b = ((st_b & 32'hFFFF_FFF8) << 4)  ^ fb_b;
  assign nx_c = ((st_c & 32'hFFFF_FFF0) << 17) ^ fb_c;

  assign ld_a = (seed_a < MIN_A) ? seed_a + MIN_A : seed_a;
  assign ld_b = (seed_b < MIN_B) ? seed_b + MIN_B : seed_b;
  assign ld_c = (seed_c < MIN_C) ? seed_c + MIN_C : seed_c;

  assign adv = step_en && !seed_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_a    <= DEF_A;
      st_b    <= DEF_B;
      st_c    <= DEF_C;
      rnd_out <= '0;
      rnd_vld <= 1'b0;
    end else if (seed_we) begin
      st_a    <= ld_a;
      st_b    <= ld_b;
      st_c    <= ld_c;
      rnd_vld <= 1'b0;
    end else if (adv) begin
      st_a    <= nx_a;
      st_b    <= nx_b;
      st_c    <= nx_c;
      rnd_out <= nx_a ^ nx_b ^ nx_c;
      rnd_vld <= 1'b1;
    end else begin
      rnd_vld <= 1'b0;
    end
  end

  // R5: a step produces a valid word on the next edge equal to the combined state
  p_step_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (rnd_vld && rnd_out == (st_a ^ st_b ^ st_c)));

  // R6: idle cycle keeps state and output
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !seed_we) |=> (!rnd_vld && $stable(rnd_out) && $stable(st_a)
                                && $stable(st_b) && $stable(st_c)));

  // R7: a seed load never yields a valid word and leaves the output alone
  p_seed_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seed_we |=> (!rnd_vld && $stable(rnd_out)));

  // R7: a loaded state keeps the high bits of a seed already above its threshold
  p_seed_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_we && seed_a >= MIN_A) |=> st_a == $past(seed_a));

  // R8: no component is ever in its lock-up region
  p_state_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_a >= MIN_A) && (st_b >= MIN_B) && (st_c >= MIN_C));
endmodule

// File: tb/sim_taus3_urng.sv
module sim_taus3_urng;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seed_we = 1'b0;
  logic [31:0] seed_a = '0, seed_b = '0, seed_c = '0;
  logic        step_en = 1'b0;
  logic [31:0] rnd_out;
  logic        rnd_vld;

  int n_tot = 0;
  int n_ok  = 0;
  bit done  = 1'b0;

  logic [31:0] ma, mb, mc, last_out;

  always #4 clk = ~clk;

  taus3_urng u0 (
    .clk(clk), .rst_n(rst_n), .seed_we(seed_we),
    .seed_a(seed_a), .seed_b(seed_b), .seed_c(seed_c),
    .step_en(step_en), .rnd_out(rnd_out), .rnd_vld(rnd_vld)
  );

  localparam int NV = 6;
  localparam logic [95:0] VEC [NV] = '{
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {32'h8000_0000, 32'h8000_0000, 32'h8000_0000},
    {32'd2,         32'd8,         32'd16},
    {32'hDEAD_BEEF, 32'hCAFE_F00D, 32'h0BAD_C0DE},
    {32'h0000_1000, 32'h0000_0010, 32'h0002_0000},
    {32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'h3C3C_C3C3}
  };
  localparam int STEPS = 8;

  function automatic logic [31:0] f_a(logic [31:0] s);
    return ((s & 32'hFFFF_FFFE) << 12) ^ (((s << 13) ^ s) >> 19);
  endfunction
  function automatic logic [31:0] f_b(logic [31:0] s);
    return ((s & 32'hFFFF_FFF8) << 4) ^ (((s << 2) ^ s) >> 25);
  endfunction
  function automatic logic [31:0] f_c(logic [31:0] s);
    return ((s & 32'hFFFF_FFF0) << 17) ^ (((s << 3) ^ s) >> 11);
  endfunction
  function automatic logic [31:0] fix(logic [31:0] s, logic [31:0] m);
    return (s < m) ? s + m : s;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tot++;
    if (act === exp) n_ok++;
    else $display("FAIL %s actual=%h expected=%h", req, act, exp);
  endtask

  task automatic load(logic [31:0] a, logic [31:0] b, logic [31:0] c, bit with_step);
    @(negedge clk);
    seed_we = 1'b1; seed_a = a; seed_b = b; seed_c = c; step_en = with_step;
    @(negedge clk);
    seed_we = 1'b0; step_en = 1'b0;
    ma = fix(a, 32'd2); mb = fix(b, 32'd8); mc = fix(c, 32'd16);
  endtask

  task automatic step(string req);
    step_en = 1'b1;
    @(negedge clk);
    step_en = 1'b0;
    ma = f_a(ma); mb = f_b(mb); mc = f_c(mc);
    check(req, {31'd0, rnd_vld}, 32'd1);
    check(req, rnd_out, ma ^ mb ^ mc);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out", rnd_out, 32'd0);
    check("R1 vld", {31'd0, rnd_vld}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    ma = 32'h1234_5678; mb = 32'h9ABC_DEF0; mc = 32'h0F1E_2D3C;
    step("R1 first step from defaults");

    // table walk: R2, R3, R4, R5 against the model
    for (int v = 0; v < NV; v++) begin
      load(VEC[v][95:64], VEC[v][63:32], VEC[v][31:0], 1'b0);
      check("R7 vld after load", {31'd0, rnd_vld}, 32'd0);
      for (int k = 0; k < STEPS; k++) step("R5 table step (R2 R3 R4)");
    end

    // R7 low seeds fixed
    load(32'd1, 32'd7, 32'd15, 1'b0);
    step("R7 low seed fix");
    load(32'd0, 32'd0, 32'd0, 1'b0);
    for (int k = 0; k < 4; k++) step("R7 zero seed fix");

    // R7 priority over step_en
    last_out = rnd_out;
    load(32'h1111_2222, 32'h3333_4444, 32'h5555_6666, 1'b1);
    check("R7 priority vld", {31'd0, rnd_vld}, 32'd0);
    check("R7 priority out held", rnd_out, last_out);
    step("R7 step after priority load");

    // R6 idle hold
    last_out = rnd_out;
    repeat (3) @(negedge clk);
    check("R6 idle vld", {31'd0, rnd_vld}, 32'd0);
    check("R6 idle out held", rnd_out, last_out);
    step("R6 state held across idle");

    // R8 long run
    load(32'h0000_0002, 32'h0000_0008, 32'h0000_0010, 1'b0);
    for (int k = 0; k < 1000; k++) step("R8 long run");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_ok, n_tot);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tot++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_ok, n_tot);
      $finish;
    end
  end
endmodule